// File: doc/BRIEF.md
# Eight-Bit Waveform Timer

This block is an 8-bit timer with a compare unit and one waveform output. A count-enable pulse from an external prescaler advances the counter by one step per pulse. A two-bit mode field selects one of four behaviours: free-running up-count, clear-on-compare, single-slope PWM, or dual-slope (up/down) PWM. Each mode fixes where the count turns around, when a new compare value takes effect and at which count the overflow flag is raised.

A simple write port lets the surrounding logic load the counter, load the compare value, write the control byte (mode, output action and a one-shot force strobe) and clear the two sticky flags. The current count, the active compare value, the control byte, the waveform output, an output-enable and both flags are visible as outputs.

The counter direction is held in a two-state machine: DIR_UP and DIR_DOWN. The only transitions are TURN_DOWN (dual-slope mode, a step taken at 0xFF) and TURN_UP (a step taken at 0x00 while falling, or any step while falling in another mode). The waveform level is a second two-state machine, WV_LOW and WV_HIGH. The transition RAISE is taken on a set or toggle action and the transition DROP on a clear or toggle action.

Top module: `wave_timer`

## Requirements
- R1: After reset the count, active compare value, control byte, both flags, the waveform output and the output-enable are all zero.
- R2: In mode 0 each `tick` raises the count by one, 0xFF wraps to 0x00 and that step sets the overflow flag. With `tick` low and no write, the count holds.
- R3: In modes 0 and 2, a compare match (a step taken while the count equals the active compare value) applies the output code in control bits [3:2]: 01 toggles, 10 drives low, 11 drives high. Code 00 changes nothing and drives `wave_en_o` low.
- R4: In mode 2 a matching step returns the count to 0x00. A compare write takes effect on the next cycle. The overflow flag only rises on a step taken at 0xFF.
- R5: In mode 3 the count runs 0x00 to 0xFF and wraps. Code 10 drives low on match and high on the wrapping step. Code 11 does the opposite. Code 01 acts like 00 and drives `wave_en_o` low.
- R6: In mode 1 the count rises to 0xFF and then falls to 0x00. The overflow flag is set by the step taken at 0x00 while falling. Code 10 drives low on a rising match and high on a falling match. Code 11 does the opposite.
- R7: In modes 1 and 3 a compare write only fills a buffer. The active value is loaded from the buffer on the step at 0xFF: the wrapping step in mode 3, the turning step in mode 1.
- R8: In modes 1 and 3, when the active compare value is 0xFF and bit 3 of the control byte is set, the match does not act on the output. Mode 3 applies the wrap action instead, and mode 1 applies the rising-match action on the turning step. With code 11 in mode 3 the output stays low for the whole period.
- R9: Control bit 4 is a force strobe. In modes 0 and 2 it applies the written output code at once. It sets no flag, leaves the count untouched and is ignored in PWM modes. It always reads back as zero.
- R10: A counter write (`wr_sel` 0) wins over a same-cycle `tick`. The first step after it produces no compare match.
- R11: Both flags are sticky. A write with `wr_sel` 3 clears the overflow flag for data bit 0 and the match flag for data bit 1. A flag event in the same cycle wins over the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Count-enable pulse from the prescaler |
| wr_en | input | 1 | Write strobe |
| wr_sel | input | 2 | Write target: 0 counter, 1 compare, 2 control, 3 flag clear |
| wr_data | input | 8 | Write data; control byte is [1:0] mode, [3:2] output code, [4] force |
| cnt_o | output | 8 | Current count |
| cmp_o | output | 8 | Active compare value |
| ctrl_o | output | 8 | Control byte readback, force bit always zero |
| wave_o | output | 1 | Waveform output level |
| wave_en_o | output | 1 | High when the output code drives the waveform |
| ovf_flag_o | output | 1 | Sticky overflow flag |
| match_flag_o | output | 1 | Sticky compare-match flag |

## Verification
The assertions assume that `wr_sel` and `wr_data` are stable whenever `wr_en` is high. They also assume the control byte is at least five bits wide, so that the force bit exists. The stimulus makes every write a single cycle driven on the falling edge. It never changes the mode while a compare update is pending, so each step taken at 0xFF acts under one settled mode. Flag clears and counter writes are sometimes placed in the same cycle as a `tick`, so that the priority rules are exercised.

// File: rtl/wt_pkg.sv
package wt_pkg;

    typedef enum logic [1:0] {
        WM_NORMAL = 2'd0,
        WM_PHASE  = 2'd1,
        WM_CTC    = 2'd2,
        WM_FAST   = 2'd3
    } wmode_e;

    typedef enum logic [1:0] {
        SEL_CNT  = 2'd0,
        SEL_CMP  = 2'd1,
        SEL_CTRL = 2'd2,
        SEL_FLAG = 2'd3
    } bsel_e;

    typedef enum logic {
        DIR_UP   = 1'b0,
        DIR_DOWN = 1'b1
    } dir_e;

    typedef enum logic {
        WV_LOW  = 1'b0,
        WV_HIGH = 1'b1
    } wv_e;

    typedef enum logic [1:0] {
        ACT_HOLD,
        ACT_SET,
        ACT_CLR,
        ACT_TOG
    } act_e;

    function automatic logic is_pwm(wmode_e m);
        return (m == WM_PHASE) || (m == WM_FAST);
    endfunction

    // action of an output code in the non-PWM modes
    function automatic act_e plain_action(logic [1:0] code);
        act_e a;
        unique case (code)
            2'b01:   a = ACT_TOG;
            2'b10:   a = ACT_CLR;
            2'b11:   a = ACT_SET;
            default: a = ACT_HOLD;
        endcase
        return a;
    endfunction

endpackage

// File: rtl/wt_counter.sv
module wt_counter
    import wt_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         adv,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  wmode_e       mode,
    input  logic         ctc_clr,
    output logic [W-1:0] cnt_o,
    output dir_e         dir_o,
    output logic         wrap_evt_o,
    output logic         top_evt_o,
    output logic         bot_evt_o
);

    localparam logic [W-1:0] TOP  = {W{1'b1}};
    localparam logic [W-1:0] ZERO = '0;
    localparam logic [W-1:0] ONE  = {{(W-1){1'b0}}, 1'b1};

    dir_e         dir_q, dir_d;
    logic [W-1:0] cnt_q, cnt_d;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dir_q <= DIR_UP;
            cnt_q <= ZERO;
        end else begin
            dir_q <= dir_d;
            cnt_q <= cnt_d;
        end
    end

    // next state: TURN_DOWN and TURN_UP are the only direction changes
    always_comb begin
        dir_d = dir_q;
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = load_val;
        end else if (adv) begin
            unique case (dir_q)
                DIR_UP: begin
                    if (mode == WM_PHASE && cnt_q == TOP) begin
                        dir_d = DIR_DOWN;
                        cnt_d = TOP - ONE;
                    end else if (ctc_clr) begin
                        cnt_d = ZERO;
                    end else begin
                        cnt_d = cnt_q + ONE;
                    end
                end
                DIR_DOWN: begin
                    if (mode != WM_PHASE) begin
                        dir_d = DIR_UP;
                        cnt_d = cnt_q + ONE;
                    end else if (cnt_q == ZERO) begin
                        dir_d = DIR_UP;
                        cnt_d = ONE;
                    end else begin
                        cnt_d = cnt_q - ONE;
                    end
                end
            endcase
        end
    end

    // outputs
    always_comb begin
        cnt_o      = cnt_q;
        dir_o      = dir_q;
        wrap_evt_o = adv && (mode != WM_PHASE) && (cnt_q == TOP);
        top_evt_o  = adv && (mode == WM_PHASE) && (dir_q == DIR_UP) && (cnt_q == TOP);
        bot_evt_o  = adv && (mode == WM_PHASE) && (dir_q == DIR_DOWN) && (cnt_q == ZERO);
    end

endmodule

// File: rtl/wt_compare.sv
module wt_compare
    import wt_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         adv,
    input  logic         cnt_wr,
    input  logic         cmp_wr,
    input  logic [W-1:0] wr_val,
    input  wmode_e       mode,
    input  logic [W-1:0] cnt,
    input  logic         upd_evt,
    output logic [W-1:0] cmp_o,
    output logic         match_evt_o
);

    logic [W-1:0] buf_q;
    logic [W-1:0] act_q;
    logic         block_q;
    logic         buffered;

    assign buffered = is_pwm(mode);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            buf_q <= '0;
            act_q <= '0;
        end else begin
            if (cmp_wr) begin
                buf_q <= wr_val;
            end
            if (cmp_wr && !buffered) begin
                act_q <= wr_val;
            end else if (upd_evt && buffered) begin
                act_q <= buf_q;
            end
        end
    end

    // a counter write masks the match of the step that follows it
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            block_q <= 1'b0;
        end else if (cnt_wr) begin
            block_q <= 1'b1;
        end else if (adv) begin
            block_q <= 1'b0;
        end
    end

    always_comb begin
        cmp_o       = act_q;
        match_evt_o = adv && !block_q && (cnt == act_q);
    end

endmodule

// File: rtl/wt_wave.sv
module wt_wave
    import wt_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  wmode_e       mode,
    input  logic [1:0]   oact,
    input  dir_e         dir,
    input  logic [W-1:0] cmp,
    input  logic         match_evt,
    input  logic         wrap_evt,
    input  logic         top_evt,
    input  logic         force_evt,
    input  logic [1:0]   force_code,
    output logic         wave_o,
    output logic         wave_en_o
);

    localparam logic [W-1:0] TOP = {W{1'b1}};

    wv_e  wv_q, wv_d;
    act_e act;
    logic at_top;

    assign at_top = (cmp == TOP);

    // action selection
    always_comb begin
        act = ACT_HOLD;
        if (force_evt) begin
            act = plain_action(force_code);
        end else begin
            unique case (mode)
                WM_NORMAL, WM_CTC: begin
                    if (match_evt) act = plain_action(oact);
                end
                WM_FAST: begin
                    if (oact[1]) begin
                        if (match_evt && !at_top)
                            act = oact[0] ? ACT_SET : ACT_CLR;
                        else if (wrap_evt)
                            act = oact[0] ? ACT_CLR : ACT_SET;
                    end
                end
                WM_PHASE: begin
                    if (oact[1]) begin
                        if (at_top && top_evt)
                            act = oact[0] ? ACT_SET : ACT_CLR;
                        else if (match_evt && !at_top) begin
                            if (dir == DIR_UP)
                                act = oact[0] ? ACT_SET : ACT_CLR;
                            else
                                act = oact[0] ? ACT_CLR : ACT_SET;
                        end
                    end
                end
            endcase
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) wv_q <= WV_LOW;
        else        wv_q <= wv_d;
    end

    // next state: RAISE and DROP
    always_comb begin
        wv_d = wv_q;
        unique case (wv_q)
            WV_LOW:  if (act == ACT_SET || act == ACT_TOG) wv_d = WV_HIGH;
            WV_HIGH: if (act == ACT_CLR || act == ACT_TOG) wv_d = WV_LOW;
        endcase
    end

    // outputs
    always_comb begin
        wave_o    = (wv_q == WV_HIGH);
        wave_en_o = is_pwm(mode) ? oact[1] : (oact != 2'b00);
    end

endmodule

// File: rtl/wave_timer.sv
module wave_timer
    import wt_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         wr_en,
    input  logic [1:0]   wr_sel,
    input  logic [W-1:0] wr_data,
    output logic [W-1:0] cnt_o,
    output logic [W-1:0] cmp_o,
    output logic [7:0]   ctrl_o,
    output logic         wave_o,
    output logic         wave_en_o,
    output logic         ovf_flag_o,
    output logic         match_flag_o
);

    localparam int NFLAG = 2;

    bsel_e  sel;
    logic   cnt_wr, cmp_wr, ctrl_wr, flg_wr;
    logic   adv;
    wmode_e mode_q, new_mode;
    logic [1:0] oact_q;
    logic   force_evt;

    logic [W-1:0] cnt, cmp_act;
    dir_e   dir;
    logic   wrap_evt, top_evt, bot_evt, match_evt;
    logic   upd_evt, ctc_clr, ovf_evt;

    assign sel      = bsel_e'(wr_sel);
    assign cnt_wr   = wr_en && (sel == SEL_CNT);
    assign cmp_wr   = wr_en && (sel == SEL_CMP);
    assign ctrl_wr  = wr_en && (sel == SEL_CTRL);
    assign flg_wr   = wr_en && (sel == SEL_FLAG);
    assign adv      = tick && !cnt_wr;
    assign new_mode = wmode_e'(wr_data[1:0]);
    assign force_evt = ctrl_wr && wr_data[4] && !is_pwm(new_mode);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= WM_NORMAL;
            oact_q <= 2'b00;
        end else if (ctrl_wr) begin
            mode_q <= new_mode;
            oact_q <= wr_data[3:2];
        end
    end

    assign upd_evt = (mode_q == WM_FAST) ? wrap_evt : top_evt;
    assign ctc_clr = match_evt && (mode_q == WM_CTC);
    assign ovf_evt = wrap_evt || bot_evt;

    wt_counter #(.W(W)) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .adv        (adv),
        .load       (cnt_wr),
        .load_val   (wr_data),
        .mode       (mode_q),
        .ctc_clr    (ctc_clr),
        .cnt_o      (cnt),
        .dir_o      (dir),
        .wrap_evt_o (wrap_evt),
        .top_evt_o  (top_evt),
        .bot_evt_o  (bot_evt)
    );

    wt_compare #(.W(W)) u_cmp (
        .clk         (clk),
        .rst_n       (rst_n),
        .adv         (adv),
        .cnt_wr      (cnt_wr),
        .cmp_wr      (cmp_wr),
        .wr_val      (wr_data),
        .mode        (mode_q),
        .cnt         (cnt),
        .upd_evt     (upd_evt),
        .cmp_o       (cmp_act),
        .match_evt_o (match_evt)
    );

    wt_wave #(.W(W)) u_wave (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode       (mode_q),
        .oact       (oact_q),
        .dir        (dir),
        .cmp        (cmp_act),
        .match_evt  (match_evt),
        .wrap_evt   (wrap_evt),
        .top_evt    (top_evt),
        .force_evt  (force_evt),
        .force_code (wr_data[3:2]),
        .wave_o     (wave_o),
        .wave_en_o  (wave_en_o)
    );

    // sticky flags: bit 0 overflow, bit 1 compare match
    logic [NFLAG-1:0] flag_set, flag_q;
    assign flag_set = {match_evt, ovf_evt};

    for (genvar g = 0; g < NFLAG; g++) begin : g_flag
        always_ff @(posedge clk) begin
            if (!rst_n) flag_q[g] <= 1'b0;
            else        flag_q[g] <= flag_set[g] || (flag_q[g] && !(flg_wr && wr_data[g]));
        end
    end

    assign cnt_o        = cnt;
    assign cmp_o        = cmp_act;
    assign ctrl_o       = {3'b000, 1'b0, oact_q, mode_q};
    assign ovf_flag_o   = flag_q[0];
    assign match_flag_o = flag_q[1];

endmodule

// File: rtl/wt_checker.sv
module wt_checker #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic         tick,
    input logic         wr_en,
    input logic [1:0]   wr_sel,
    input logic [W-1:0] wr_data,
    input logic [W-1:0] cnt_o,
    input logic [W-1:0] cmp_o,
    input logic [7:0]   ctrl_o,
    input logic         wave_o,
    input logic         wave_en_o,
    input logic         ovf_flag_o,
    input logic         match_flag_o
);

    localparam logic [W-1:0] TOP = {W{1'b1}};

    AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !wr_en) |=> $stable(cnt_o)); // R2

    AST_NORMAL_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !wr_en && ctrl_o[1:0] == 2'd0 && cnt_o == TOP) |=> (cnt_o == '0 && ovf_flag_o)); // R2

    AST_WAVE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !wr_en) |=> $stable(wave_o)); // R3

    AST_PWM_CMP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && (ctrl_o[1:0] == 2'd1 || ctrl_o[1:0] == 2'd3)) |=> $stable(cmp_o)); // R7

    AST_FAST_RESERVED: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_o[1:0] == 2'd3 && ctrl_o[3:2] == 2'b01) |-> !wave_en_o); // R5

    AST_CTRL_READBACK: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == 2'd2) |=> (ctrl_o == {4'b0000, $past(wr_data[3:0])})); // R9

    AST_FORCE_NO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == 2'd2 && wr_data[4] && !tick && !match_flag_o) |=> !match_flag_o); // R9

    AST_CNT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == 2'd0) |=> (cnt_o == $past(wr_data))); // R10

    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_flag_o && !(wr_en && wr_sel == 2'd3 && wr_data[0])) |=> ovf_flag_o); // R11

    AST_MATCH_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (match_flag_o && !(wr_en && wr_sel == 2'd3 && wr_data[1])) |=> match_flag_o); // R11

endmodule

bind wave_timer wt_checker #(.W(W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .tick         (tick),
    .wr_en        (wr_en),
    .wr_sel       (wr_sel),
    .wr_data      (wr_data),
    .cnt_o        (cnt_o),
    .cmp_o        (cmp_o),
    .ctrl_o       (ctrl_o),
    .wave_o       (wave_o),
    .wave_en_o    (wave_en_o),
    .ovf_flag_o   (ovf_flag_o),
    .match_flag_o (match_flag_o)
);

// File: tb/wave_timer_tb.sv
module wave_timer_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_sel = 2'd0;
    logic [7:0] wr_data = 8'd0;
    logic [7:0] cnt_o, cmp_o, ctrl_o;
    logic       wave_o, wave_en_o, ovf_flag_o, match_flag_o;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    wave_timer dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .tick         (tick),
        .wr_en        (wr_en),
        .wr_sel       (wr_sel),
        .wr_data      (wr_data),
        .cnt_o        (cnt_o),
        .cmp_o        (cmp_o),
        .ctrl_o       (ctrl_o),
        .wave_o       (wave_o),
        .wave_en_o    (wave_en_o),
        .ovf_flag_o   (ovf_flag_o),
        .match_flag_o (match_flag_o)
    );

    typedef struct packed {
        logic [1:0] sel;
        logic [7:0] data;
        logic [9:0] ticks;
        logic [7:0] cnt;
        logic       wave;
        logic       ovf;
        logic       mtc;
    } vec_t;

    // normal mode sequence: one write, then a number of steps, then expected state
    localparam vec_t VECS [12] = '{
        '{2'd2, 8'h04, 10'd0, 8'h00, 1'b0, 1'b0, 1'b0},
        '{2'd1, 8'h05, 10'd5, 8'h05, 1'b0, 1'b0, 1'b0},
        '{2'd3, 8'h00, 10'd1, 8'h06, 1'b1, 1'b0, 1'b1},
        '{2'd3, 8'h02, 10'd0, 8'h06, 1'b1, 1'b0, 1'b0},
        '{2'd0, 8'hFD, 10'd3, 8'h00, 1'b1, 1'b1, 1'b0},
        '{2'd3, 8'h00, 10'd6, 8'h06, 1'b0, 1'b1, 1'b1},
        '{2'd3, 8'h03, 10'd0, 8'h06, 1'b0, 1'b0, 1'b0},
        '{2'd0, 8'h05, 10'd1, 8'h06, 1'b0, 1'b0, 1'b0},
        '{2'd2, 8'h0C, 10'd0, 8'h06, 1'b0, 1'b0, 1'b0},
        '{2'd0, 8'h04, 10'd2, 8'h06, 1'b1, 1'b0, 1'b1},
        '{2'd2, 8'h08, 10'd0, 8'h06, 1'b1, 1'b0, 1'b1},
        '{2'd0, 8'h03, 10'd3, 8'h06, 1'b0, 1'b0, 1'b1}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic cyc(input logic t, input logic w, input logic [1:0] s, input logic [7:0] d);
        @(negedge clk);
        tick = t; wr_en = w; wr_sel = s; wr_data = d;
        @(posedge clk);
        #1;
    endtask

    task automatic steps(input int n);
        for (int i = 0; i < n; i++) cyc(1'b1, 1'b0, 2'd0, 8'd0);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; tick = 1'b0; wr_en = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        do_reset();
        // R1 reset state
        chk("R1 cnt", cnt_o, 8'h00);
        chk("R1 cmp", cmp_o, 8'h00);
        chk("R1 ctrl", ctrl_o, 8'h00);
        chk("R1 wave", wave_o, 1'b0);
        chk("R1 wave_en", wave_en_o, 1'b0);
        chk("R1 flags", {ovf_flag_o, match_flag_o}, 2'b00);

        // table walk in normal mode
        for (int i = 0; i < 12; i++) begin
            cyc(1'b0, 1'b1, VECS[i].sel, VECS[i].data);
            steps(int'(VECS[i].ticks));
            chk("R2 table cnt", cnt_o, VECS[i].cnt);
            chk("R3 table wave", wave_o, VECS[i].wave);
            chk("R11 table ovf", ovf_flag_o, VECS[i].ovf);
            chk("R10 table match", match_flag_o, VECS[i].mtc);
        end
        repeat (4) cyc(1'b0, 1'b0, 2'd0, 8'd0);
        chk("R2 hold without tick", cnt_o, 8'h06);
        cyc(1'b0, 1'b1, 2'd2, 8'h00);
        chk("R3 code 00 disconnects", wave_en_o, 1'b0);

        // mid-run reset
        do_reset();
        chk("R1 cnt after reset", cnt_o, 8'h00);
        chk("R1 flags after reset", {ovf_flag_o, match_flag_o}, 2'b00);

        // R4 clear-on-compare
        cyc(1'b0, 1'b1, 2'd2, 8'h06);
        cyc(1'b0, 1'b1, 2'd1, 8'h03);
        chk("R4 cmp immediate", cmp_o, 8'h03);
        steps(4);
        chk("R4 cnt cleared", cnt_o, 8'h00);
        chk("R4 wave toggled", wave_o, 1'b1);
        chk("R4 match flag", match_flag_o, 1'b1);
        chk("R4 no ovf", ovf_flag_o, 1'b0);
        steps(4);
        chk("R4 second period cnt", cnt_o, 8'h00);
        chk("R4 second toggle", wave_o, 1'b0);
        cyc(1'b0, 1'b1, 2'd3, 8'h03);
        chk("R11 cleared", match_flag_o, 1'b0);
        steps(3);
        cyc(1'b1, 1'b1, 2'd3, 8'h02);
        chk("R11 set wins over clear", match_flag_o, 1'b1);
        chk("R4 cnt after match", cnt_o, 8'h00);

        // R9 force strobe
        do_reset();
        cyc(1'b0, 1'b1, 2'd2, 8'h14);
        chk("R9 force toggles", wave_o, 1'b1);
        chk("R9 force no flag", match_flag_o, 1'b0);
        chk("R9 force reads zero", ctrl_o, 8'h04);
        cyc(1'b0, 1'b1, 2'd0, 8'h07);
        cyc(1'b0, 1'b1, 2'd2, 8'h1A);
        chk("R9 force clears in CTC", wave_o, 1'b0);
        chk("R9 force keeps count", cnt_o, 8'h07);
        cyc(1'b0, 1'b1, 2'd2, 8'h1F);
        chk("R9 force ignored in PWM", wave_o, 1'b0);

        // R5 and R7 single-slope PWM
        do_reset();
        cyc(1'b0, 1'b1, 2'd2, 8'h0B);
        cyc(1'b0, 1'b1, 2'd1, 8'h03);
        chk("R7 buffered write", cmp_o, 8'h00);
        steps(256);
        chk("R7 load at wrap", cmp_o, 8'h03);
        chk("R5 set at bottom", wave_o, 1'b1);
        chk("R5 ovf at max", ovf_flag_o, 1'b1);
        steps(3);
        chk("R5 before match", wave_o, 1'b1);
        steps(1);
        chk("R5 clear on match", wave_o, 1'b0);
        chk("R5 cnt", cnt_o, 8'h04);
        cyc(1'b0, 1'b1, 2'd2, 8'h0F);
        steps(252);
        chk("R5 inverting clear at bottom", wave_o, 1'b0);
        chk("R5 wrap cnt", cnt_o, 8'h00);
        steps(4);
        chk("R5 inverting set on match", wave_o, 1'b1);
        cyc(1'b0, 1'b1, 2'd2, 8'h07);
        chk("R5 code 01 disconnected", wave_en_o, 1'b0);

        // R8 compare at top in single-slope PWM
        do_reset();
        cyc(1'b0, 1'b1, 2'd2, 8'h0F);
        cyc(1'b0, 1'b1, 2'd1, 8'hFF);
        steps(256);
        chk("R8 cmp loaded", cmp_o, 8'hFF);
        chk("R8 low after wrap", wave_o, 1'b0);
        steps(128);
        chk("R8 low mid period", wave_o, 1'b0);
        steps(128);
        chk("R8 match ignored at top", wave_o, 1'b0);
        chk("R8 cnt", cnt_o, 8'h00);

        // R6 dual-slope PWM
        do_reset();
        cyc(1'b0, 1'b1, 2'd2, 8'h09);
        cyc(1'b0, 1'b1, 2'd1, 8'h10);
        steps(255);
        chk("R6 reach top", cnt_o, 8'hFF);
        steps(1);
        chk("R6 turn down", cnt_o, 8'hFE);
        chk("R7 load at top", cmp_o, 8'h10);
        steps(238);
        chk("R6 falling cnt", cnt_o, 8'h10);
        chk("R6 low before down match", wave_o, 1'b0);
        steps(1);
        chk("R6 set on down match", wave_o, 1'b1);
        steps(15);
        chk("R6 at bottom", cnt_o, 8'h00);
        chk("R6 no ovf yet", ovf_flag_o, 1'b0);
        steps(1);
        chk("R6 ovf at bottom", ovf_flag_o, 1'b1);
        chk("R6 turn up", cnt_o, 8'h01);
        steps(16);
        chk("R6 clear on up match", wave_o, 1'b0);
        chk("R6 rising cnt", cnt_o, 8'h11);

        cyc(1'b0, 1'b0, 2'd0, 8'd0);
        finished = 1;
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule